// File: doc/BRIEF.md
# SDRAM Burst Column Address Generator

This block turns one column command into the stream of column addresses that a synchronous DRAM walks through during a burst. It produces one address per clock. A start pulse carries the first column together with the mode settings: burst length, burst ordering, and whether writes are limited to single accesses. The block then steps through the burst. Each cycle it drives the current column, a valid flag and a last-beat flag.

A burst can be cut short in two ways. A stop input ends it, and a new start replaces it at once, so column commands can arrive back to back every clock. In full-page mode the column keeps counting around the whole row until a stop or a restart arrives. The block suits an SDRAM device model, where it drives the column decoder, and a controller-side data-path checker, where it predicts which column each data beat belongs to.

Top module: `burst_col_gen`

## Requirements
- R1: While reset is asserted and after it is released, with no start yet, valid_o and last_o are 0 and col_o is 0.
- R2: On the cycle after start_i is sampled high, valid_o is 1 and col_o equals the sampled start_col_i. The length, ordering and write fields are captured at start, and later changes to them do not affect the burst in progress.
- R3: The burst length code len_code_i decodes as follows: 3'b000 gives 1 beat, 3'b001 gives 2, 3'b010 gives 4, 3'b011 gives 8 and 3'b111 gives full page. The reserved codes 3'b100, 3'b101 and 3'b110 behave as length 1.
- R4: Sequential order (interleave_i=0): beat n carries the low log2(BL) bits of start+n, wrapping inside the block. The upper column bits stay equal to those of the start column.
- R5: Interleaved order (interleave_i=1): beat n carries the start column with its low log2(BL) bits XORed with n.
- R6: Full page: beat n is (start+n) mod 1024 whatever interleave_i is, and the burst continues with no end until a stop or a start.
- R7: last_o is 1 exactly on beat BL-1 of a finite burst and never in full-page mode. valid_o drops the cycle after the last beat unless a start is sampled on that cycle.
- R8: A stop_i sampled without start_i during a burst makes valid_o and last_o 0 on the next cycle. A stop while idle has no effect.
- R9: A start during a burst restarts the sequence at once from the new column. When start_i and stop_i are high together, start wins.
- R10: With write_single_i=1, a start with is_write_i=1 uses length 1. Reads keep the programmed length. With write_single_i=0, writes use the programmed length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Column command: begin a burst |
| start_col_i | input | 10 | First column of the burst |
| len_code_i | input | 3 | Burst length code |
| interleave_i | input | 1 | 1 = interleaved order, 0 = sequential |
| is_write_i | input | 1 | Column command is a write |
| write_single_i | input | 1 | Writes limited to a single beat |
| stop_i | input | 1 | Terminate the burst in progress |
| col_o | output | 10 | Column of the current beat |
| valid_o | output | 1 | A beat is being presented |
| last_o | output | 1 | Current beat is the final one |

## Verification
The assertions assume that every input is a known 0 or 1 from the first clock edge and is held steady across each rising edge. They also assume that start_col_i and the mode fields matter only on the cycles where start_i is high. The stimulus changes every input only on falling edges and keeps stop_i and start_i at 0 outside the cycles that drive them on purpose. It also changes the mode fields in the middle of a burst, which is allowed because the design is expected to ignore those changes.

// File: rtl/burst_col_pkg.sv
package burst_col_pkg;

    localparam int COL_BITS = 10;

    typedef enum logic [2:0] {
        BL_ONE   = 3'b000,
        BL_TWO   = 3'b001,
        BL_FOUR  = 3'b010,
        BL_EIGHT = 3'b011,
        BL_PAGE  = 3'b111
    } burst_len_e;

endpackage

// File: rtl/burst_len_decode.sv
module burst_len_decode
    import burst_col_pkg::*;
#(
    parameter int COL_W = COL_BITS
) (
    input  logic [2:0]       len_code_i,
    input  logic             is_write_i,
    input  logic             write_single_i,
    output logic [COL_W-1:0] mask_o,
    output logic [COL_W-1:0] lenm1_o,
    output logic             full_o
);

    localparam logic [COL_W-1:0] ALL_ONES = '1;

    always_comb begin
        mask_o  = '0;
        lenm1_o = '0;
        full_o  = 1'b0;
        if (!(is_write_i && write_single_i)) begin
            case (len_code_i)
                BL_TWO: begin
                    mask_o  = COL_W'(1);
                    lenm1_o = COL_W'(1);
                end
                BL_FOUR: begin
                    mask_o  = COL_W'(3);
                    lenm1_o = COL_W'(3);
                end
                BL_EIGHT: begin
                    mask_o  = COL_W'(7);
                    lenm1_o = COL_W'(7);
                end
                BL_PAGE: begin
                    mask_o  = ALL_ONES;
                    lenm1_o = ALL_ONES;
                    full_o  = 1'b1;
                end
                default: begin
                    mask_o  = '0;
                    lenm1_o = '0;
                end
            endcase
        end
    end

endmodule

// File: rtl/burst_addr_calc.sv
module burst_addr_calc
    import burst_col_pkg::*;
#(
    parameter int COL_W = COL_BITS
) (
    input  logic [COL_W-1:0] base_i,
    input  logic [COL_W-1:0] beat_i,
    input  logic [COL_W-1:0] mask_i,
    input  logic             ilv_i,
    output logic [COL_W-1:0] col_o
);

    logic [COL_W-1:0] sum;

    assign sum = base_i + beat_i;

    for (genvar b = 0; b < COL_W; b++) begin : g_bit
        logic moved;
        assign moved    = ilv_i ? (base_i[b] ^ beat_i[b]) : sum[b];
        assign col_o[b] = mask_i[b] ? moved : base_i[b];
    end

endmodule

// File: rtl/burst_col_gen.sv
module burst_col_gen
    import burst_col_pkg::*;
#(
    parameter int COL_W = COL_BITS
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [COL_W-1:0] start_col_i,
    input  logic [2:0]       len_code_i,
    input  logic             interleave_i,
    input  logic             is_write_i,
    input  logic             write_single_i,
    input  logic             stop_i,
    output logic [COL_W-1:0] col_o,
    output logic             valid_o,
    output logic             last_o
);

    typedef struct packed {
        logic             active;
        logic             last;
        logic             full;
        logic             ilv;
        logic [COL_W-1:0] beat;
        logic [COL_W-1:0] base;
        logic [COL_W-1:0] mask;
        logic [COL_W-1:0] lenm1;
        logic [COL_W-1:0] col;
    } seq_state_t;

    seq_state_t st_d, st_q;

    logic [COL_W-1:0] dec_mask;
    logic [COL_W-1:0] dec_lenm1;
    logic             dec_full;
    logic [COL_W-1:0] beat_inc;
    logic [COL_W-1:0] step_col;

    burst_len_decode #(.COL_W(COL_W)) u_decode (
        .len_code_i     (len_code_i),
        .is_write_i     (is_write_i),
        .write_single_i (write_single_i),
        .mask_o         (dec_mask),
        .lenm1_o        (dec_lenm1),
        .full_o         (dec_full)
    );

    assign beat_inc = st_q.beat + COL_W'(1);

    burst_addr_calc #(.COL_W(COL_W)) u_calc (
        .base_i (st_q.base),
        .beat_i (beat_inc),
        .mask_i (st_q.mask),
        .ilv_i  (st_q.ilv),
        .col_o  (step_col)
    );

    always_comb begin
        st_d = st_q;
        if (start_i) begin
            st_d.active = 1'b1;
            st_d.beat   = '0;
            st_d.base   = start_col_i;
            st_d.mask   = dec_mask;
            st_d.lenm1  = dec_lenm1;
            st_d.full   = dec_full;
            st_d.ilv    = interleave_i & ~dec_full;
            st_d.col    = start_col_i;
            st_d.last   = ~dec_full && (dec_lenm1 == '0);
        end else if (st_q.active && (stop_i || st_q.last)) begin
            st_d.active = 1'b0;
            st_d.last   = 1'b0;
        end else if (st_q.active) begin
            st_d.beat = beat_inc;
            st_d.col  = step_col;
            st_d.last = ~st_q.full && (beat_inc == st_q.lenm1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign col_o   = st_q.col;
    assign valid_o = st_q.active;
    assign last_o  = st_q.last;

    a_r7_last_with_valid: assert property (@(posedge clk) disable iff (!rst_n)
        last_o |-> valid_o);

    a_r2_start_loads: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> (valid_o && col_o == $past(start_col_i)));

    a_r8_stop_ends: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_i && !start_i) |=> (!valid_o && !last_o));

    a_r7_ends_after_last: assert property (@(posedge clk) disable iff (!rst_n)
        (last_o && !start_i) |=> !valid_o);

    a_r6_page_no_last: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.full |-> !last_o);

    a_r6_page_step: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && st_q.full && !start_i && !stop_i) |=> (col_o == $past(col_o) + COL_W'(1)));

    a_r4_upper_fixed: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && !last_o && !start_i && !stop_i)
        |=> ((col_o & ~st_q.mask) == ($past(col_o) & ~$past(st_q.mask))));

endmodule

// File: tb/burst_col_gen_test.sv
module burst_col_gen_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_i = 1'b0;
    logic [9:0] start_col_i = '0;
    logic [2:0] len_code_i = '0;
    logic       interleave_i = 1'b0;
    logic       is_write_i = 1'b0;
    logic       write_single_i = 1'b0;
    logic       stop_i = 1'b0;
    logic [9:0] col_o;
    logic       valid_o;
    logic       last_o;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    burst_col_gen uut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .start_col_i(start_col_i),
        .len_code_i(len_code_i), .interleave_i(interleave_i), .is_write_i(is_write_i),
        .write_single_i(write_single_i), .stop_i(stop_i),
        .col_o(col_o), .valid_o(valid_o), .last_o(last_o)
    );

    // vector: {col[15:6], len[5:3], il[2], wr[1], ws[0]}
    localparam logic [15:0] VEC [10] = '{
        {10'h005, 3'b001, 1'b0, 1'b0, 1'b0},
        {10'h00D, 3'b010, 1'b0, 1'b0, 1'b0},
        {10'h00D, 3'b010, 1'b1, 1'b0, 1'b0},
        {10'h3FB, 3'b011, 1'b0, 1'b0, 1'b0},
        {10'h3FB, 3'b011, 1'b1, 1'b0, 1'b0},
        {10'h123, 3'b000, 1'b0, 1'b0, 1'b0},
        {10'h0A6, 3'b101, 1'b1, 1'b0, 1'b0},
        {10'h0A6, 3'b011, 1'b0, 1'b1, 1'b1},
        {10'h0A6, 3'b011, 1'b1, 1'b1, 1'b0},
        {10'h2C9, 3'b010, 1'b1, 1'b0, 1'b1}
    };

    function automatic int exp_len(logic [2:0] code, logic wr, logic ws);
        if (wr && ws) return 1;
        case (code)
            3'b001:  return 2;
            3'b010:  return 4;
            3'b011:  return 8;
            default: return 1;
        endcase
    endfunction

    function automatic logic [9:0] exp_col(logic [9:0] base, int n, int bl, logic il);
        logic [9:0] m;
        logic [9:0] nn;
        m  = 10'(bl - 1);
        nn = 10'(n);
        if (il) return (base & ~m) | ((base ^ nn) & m);
        return (base & ~m) | ((base + nn) & m);
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic pulse_start(logic [9:0] c, logic [2:0] len, logic il, logic wr, logic ws);
        start_col_i = c; len_code_i = len; interleave_i = il;
        is_write_i = wr; write_single_i = ws; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 valid", 32'(valid_o), 0);
        check("R1 last", 32'(last_o), 0);
        check("R1 col", 32'(col_o), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 idle valid", 32'(valid_o), 0);

        // table walk: R3 R4 R5 R7 R10
        for (int v = 0; v < 10; v++) begin
            logic [9:0] c;
            int bl;
            c  = VEC[v][15:6];
            bl = exp_len(VEC[v][5:3], VEC[v][1], VEC[v][0]);
            pulse_start(c, VEC[v][5:3], VEC[v][2], VEC[v][1], VEC[v][0]);
            for (int n = 0; n < bl; n++) begin
                check(VEC[v][2] ? "R5 col" : "R4 col", 32'(col_o),
                      32'(exp_col(c, n, bl, VEC[v][2])));
                check("R3 valid", 32'(valid_o), 1);
                check("R7 last", 32'(last_o), (n == bl - 1) ? 1 : 0);
                @(negedge clk);
            end
            check("R7 end valid", 32'(valid_o), 0);
            check("R10 end last", 32'(last_o), 0);
        end

        // R8: stop mid-burst
        pulse_start(10'h040, 3'b011, 1'b0, 1'b0, 1'b0);
        @(negedge clk);
        check("R8 beat1", 32'(col_o), 32'h041);
        stop_i = 1'b1;
        @(negedge clk);
        stop_i = 1'b0;
        check("R8 stopped valid", 32'(valid_o), 0);
        check("R8 stopped last", 32'(last_o), 0);
        // R8: stop while idle
        stop_i = 1'b1;
        @(negedge clk);
        stop_i = 1'b0;
        @(negedge clk);
        check("R8 idle stop", 32'(valid_o), 0);

        // R9: restart mid-burst with start and stop together
        pulse_start(10'h100, 3'b010, 1'b0, 1'b0, 1'b0);
        stop_i = 1'b1;
        pulse_start(10'h207, 3'b010, 1'b1, 1'b0, 1'b0);
        stop_i = 1'b0;
        check("R9 restart col", 32'(col_o), 32'h207);
        check("R9 restart valid", 32'(valid_o), 1);
        @(negedge clk);
        check("R9 next", 32'(col_o), 32'h206);

        // R2: mode change mid-burst ignored
        @(negedge clk); @(negedge clk); @(negedge clk);
        pulse_start(10'h011, 3'b010, 1'b0, 1'b0, 1'b0);
        len_code_i = 3'b000; interleave_i = 1'b1;
        @(negedge clk);
        check("R2 held len", 32'(last_o), 0);
        check("R2 held order", 32'(col_o), 32'h012);
        @(negedge clk); @(negedge clk);
        check("R2 held last", 32'(last_o), 1);
        check("R2 held col", 32'(col_o), 32'h010);
        @(negedge clk);

        // R6: full page wraps, no last, interleave ignored
        pulse_start(10'h3FD, 3'b111, 1'b1, 1'b0, 1'b0);
        for (int n = 0; n < 6; n++) begin
            check("R6 col", 32'(col_o), 32'(10'(10'h3FD + 10'(n))));
            check("R6 last", 32'(last_o), 0);
            @(negedge clk);
        end
        repeat (1100) @(negedge clk);
        check("R6 still valid", 32'(valid_o), 1);
        check("R6 long col", 32'(col_o), 32'(10'(10'h3FD + 10'd1106)));
        stop_i = 1'b1;
        @(negedge clk);
        stop_i = 1'b0;
        check("R6 stop", 32'(valid_o), 0);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule